// File: doc/BRIEF.md
# Prioritised Interrupt Line Controller

This block collects a parameterised set of device interrupt lines (64 by default) and keeps four pieces of state for each line: whether it is enabled, whether it is pending, whether it is being serviced, and a four-bit priority level. A rising edge on a line makes it pending. Software can also make a line pending by writing its number to a trigger register. Software reads and writes all of this state through a small word-addressed register bus with byte strobes. Each read returns its data one cycle after the request.

On every cycle a combinational arbiter looks at the lines that are pending, enabled and not in service. It offers the best of them to the core as an interrupt number and a priority. The core takes the offer with an acknowledge strobe, which moves the line from pending to in service. It later closes the handler with a completion strobe that carries the line number. A new request is offered only when it would preempt every handler already in service.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Line n is bit n%32 of word n/32 in each bit bank. Bus word addresses are: set-enable 0x00+w, clear-enable 0x08+w, set-pending 0x10+w, clear-pending 0x18+w, in-service 0x20+w, priority 0x80+k, trigger 0xC0. A bank word w at or beyond ceil(lines/32) reads as zero and ignores writes, and so does any unlisted address.
- R2: In the set-enable bank a 1 enables the line, and in the clear-enable bank a 1 disables it. A 0 bit leaves the line unchanged. Only bits in byte lanes whose strobe is high take effect, with lane b covering data bits 8b+7..8b.
- R3: Reading either the set-enable word or the clear-enable word returns the current enable bits.
- R4: A 1 written to the set-pending bank makes the line pending, and setting a line that is already pending changes nothing. Reading either the set-pending word or the clear-pending word returns the pending bits.
- R5: A 1 written to the clear-pending bank clears the pending bit, except on a line that is in service, where the write has no effect.
- R6: The in-service bank reads back the in-service bits, and writes to it are ignored.
- R7: Priority word k holds line 4k+b in byte lane b. Only the upper four bits of each byte are stored, and the lower four read back as zero. A byte-strobed write changes only the lanes whose strobe is high.
- R8: A write to the trigger register makes line v pending, where v is data bits 8..0, when v < 240 and v is below the line count. Any other value is ignored. Byte strobes are not used by this register.
- R9: A low-to-high transition on an input line sets its pending bit once. Holding the line high does not set the bit again.
- R10: Among lines that are pending, enabled and not in service, the lowest priority value wins, and on a tie the lowest line number wins.
- R11: A request is raised only when the winner's priority value is strictly below that of every line in service.
- R12: An acknowledge while a request is raised clears that line's pending bit and sets its in-service bit. An acknowledge with no request is ignored. A completion strobe clears the in-service bit of the line it names. When a set and a clear of the pending bit fall in the same cycle, the set wins.
- R13: After reset every line is disabled, not pending and not in service, with priority 0. A read request returns its data, with the valid flag high, on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | NUM_LINES | Device interrupt inputs, edge sensitive |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte lane strobes |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the request |
| bus_rdata_o | output | 32 | Read data |
| irq_req_o | output | 1 | Interrupt offered to the core |
| irq_id_o | output | ID_W | Number of the offered line |
| irq_prio_o | output | 4 | Priority of the offered line |
| irq_ack_i | input | 1 | Core takes the offered line |
| irq_done_i | input | 1 | Core finishes a handler |
| irq_done_id_i | input | ID_W | Line whose handler finished |

## Verification
The arbiter is tried against pending sets of several shapes. A set with distinct priorities shows whether the minimum search works. A priority tie between two lines exposes a reversed tie-break. A disabled pending line shows whether the enable gate is applied. A higher-priority line arriving while another is in service separates a strict preemption threshold from a non-strict one. The register banks are tried with partial byte strobes, bits written as zero, writes to the read-only in-service bank, and a clear-pending write aimed at a line in service. These show whether a write leaks into lanes or lines it should not touch. Trigger values inside the line count are tried against values outside it, and a line held high is tried against one that falls and rises again. Together these separate edge detection from level detection.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned PRIO_W     = 4;
  localparam int unsigned TRIG_LIMIT = 240;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_EN_SET, SEL_EN_CLR, SEL_PD_SET,
    SEL_PD_CLR, SEL_ACTIVE, SEL_PRIO, SEL_TRIG
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [5:0] idx;
  } decode_t;

  // Word address to register group and index within the group.
  function automatic decode_t decode_addr(logic [ADDR_W-1:0] a);
    decode_t d;
    d.sel = SEL_NONE;
    d.idx = '0;
    if (a[7:6] == 2'b10) begin
      d.sel = SEL_PRIO;
      d.idx = a[5:0];
    end else if (a == 8'hC0) begin
      d.sel = SEL_TRIG;
    end else if (a[7:6] == 2'b00) begin
      d.idx = {3'b000, a[2:0]};
      case (a[5:3])
        3'd0: d.sel = SEL_EN_SET;
        3'd1: d.sel = SEL_EN_CLR;
        3'd2: d.sel = SEL_PD_SET;
        3'd3: d.sel = SEL_PD_CLR;
        3'd4: d.sel = SEL_ACTIVE;
        default: d.sel = SEL_NONE;
      endcase
    end
    return d;
  endfunction

  // Byte strobes expanded to a bit mask.
  function automatic logic [DATA_W-1:0] lane_mask(logic [3:0] be);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  // Bits of each byte lane that are never stored.
  function automatic logic [DATA_W-1:0] unstored_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < 4; b++) m[b*8 +: (8-PRIO_W)] = '1;
    return m;
  endfunction
endpackage

// File: rtl/ipc_edge_detect.sv
module ipc_edge_detect #(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [NUM_LINES-1:0] rise_o
);
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lines_i;
  end

  assign rise_o = lines_i & ~prev_q;

  // A held-high line yields one pulse only.
  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/ipc_line_state.sv
module ipc_line_state #(
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] set_en_i,
  input  logic [NUM_LINES-1:0] clr_en_i,
  input  logic [NUM_LINES-1:0] set_pd_i,
  input  logic [NUM_LINES-1:0] clr_pd_i,
  input  logic [NUM_LINES-1:0] ack_mask_i,
  input  logic [NUM_LINES-1:0] done_mask_i,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] pd_o,
  output logic [NUM_LINES-1:0] act_o
);
  logic [NUM_LINES-1:0] en_q, pd_q, act_q;
  logic [NUM_LINES-1:0] pd_drop;

  // Clear-pending spares lines in service; any set wins over a clear.
  assign pd_drop = (clr_pd_i & ~act_q) | ack_mask_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pd_q  <= '0;
      act_q <= '0;
    end else begin
      en_q  <= (en_q | set_en_i) & ~clr_en_i;
      pd_q  <= (pd_q & ~pd_drop) | set_pd_i;
      act_q <= (act_q & ~done_mask_i) | ack_mask_i;
    end
  end

  assign en_o  = en_q;
  assign pd_o  = pd_q;
  assign act_o = act_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    assert_active_keeps_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q[i] && pd_q[i]) |=> pd_q[i]);
    assert_ack_sets_active_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_mask_i[i] |=> act_q[i]);
    assert_done_clears_active_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_mask_i[i] && !ack_mask_i[i]) |=> !act_q[i]);
  end
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
  import ipc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned ID_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_LINES-1:0]              pd_i,
  input  logic [NUM_LINES-1:0]              en_i,
  input  logic [NUM_LINES-1:0]              act_i,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0]  prio_i,
  output logic                              req_o,
  output logic [ID_W-1:0]                   id_o,
  output logic [PRIO_W-1:0]                 prio_o
);
  logic [NUM_LINES-1:0] cand;
  logic                 best_found, any_act;
  logic [ID_W-1:0]      best_id;
  logic [PRIO_W-1:0]    best_p, min_act;

  assign cand = pd_i & en_i & ~act_i;

  // Upward scan with a strict compare keeps the lowest number on ties.
  always_comb begin
    best_found = 1'b0;
    best_id    = '0;
    best_p     = '1;
    any_act    = 1'b0;
    min_act    = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (act_i[i] && (!any_act || prio_i[i] < min_act)) begin
        any_act = 1'b1;
        min_act = prio_i[i];
      end
      if (cand[i] && (!best_found || prio_i[i] < best_p)) begin
        best_found = 1'b1;
        best_p     = prio_i[i];
        best_id    = ID_W'(i);
      end
    end
  end

  assign req_o  = best_found && (!any_act || best_p < min_act);
  assign id_o   = best_id;
  assign prio_o = best_p;

  assert_winner_is_candidate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> cand[id_o]);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    assert_no_better_candidate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && cand[i]) |-> (prio_i[id_o] < prio_i[i] ||
                              (prio_i[id_o] == prio_i[i] && int'(id_o) <= i)));
    assert_preempts_active_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && act_i[i]) |-> (prio_o < prio_i[i]));
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import ipc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned ID_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [7:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  input  logic [3:0]           bus_be_i,
  output logic                 bus_rvalid_o,
  output logic [31:0]          bus_rdata_o,
  output logic                 irq_req_o,
  output logic [ID_W-1:0]      irq_id_o,
  output logic [3:0]           irq_prio_o,
  input  logic                 irq_ack_i,
  input  logic                 irq_done_i,
  input  logic [ID_W-1:0]      irq_done_id_i
);
  localparam int unsigned NUM_WORDS = (NUM_LINES + 31) / 32;
  localparam int unsigned PAD_W     = NUM_WORDS * 32;

  decode_t              dec;
  logic                 wr_hit, rd_hit;
  logic [DATA_W-1:0]    wmasked, rd_word;
  logic [PAD_W-1:0]     set_en_pad, clr_en_pad, set_pd_pad, clr_pd_pad;
  logic [PAD_W-1:0]     en_pad, pd_pad, act_pad;
  logic [NUM_LINES-1:0] en, pd, act, rise, trig_mask, ack_mask, done_mask, set_pd_all;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  logic [8:0]           trig_num;

  assign dec     = decode_addr(bus_addr_i);
  assign wr_hit  = bus_valid_i && bus_write_i;
  assign rd_hit  = bus_valid_i && !bus_write_i;
  assign wmasked = bus_wdata_i & lane_mask(bus_be_i);
  assign trig_num = bus_wdata_i[8:0];

  // Bit-bank write decode into per-line set/clear vectors.
  always_comb begin
    set_en_pad = '0;
    clr_en_pad = '0;
    set_pd_pad = '0;
    clr_pd_pad = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wr_hit && int'(dec.idx) == w) begin
        case (dec.sel)
          SEL_EN_SET: set_en_pad[w*32 +: 32] = wmasked;
          SEL_EN_CLR: clr_en_pad[w*32 +: 32] = wmasked;
          SEL_PD_SET: set_pd_pad[w*32 +: 32] = wmasked;
          SEL_PD_CLR: clr_pd_pad[w*32 +: 32] = wmasked;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      trig_mask[i] = wr_hit && dec.sel == SEL_TRIG && int'(trig_num) < TRIG_LIMIT &&
                     int'(trig_num) == i;
      ack_mask[i]  = irq_ack_i && irq_req_o && irq_id_o == ID_W'(i);
      done_mask[i] = irq_done_i && irq_done_id_i == ID_W'(i);
    end
  end

  assign set_pd_all = set_pd_pad[NUM_LINES-1:0] | trig_mask | rise;

  ipc_edge_detect #(.NUM_LINES(NUM_LINES)) i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (irq_lines_i),
    .rise_o  (rise)
  );

  ipc_line_state #(.NUM_LINES(NUM_LINES)) i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_en_i    (set_en_pad[NUM_LINES-1:0]),
    .clr_en_i    (clr_en_pad[NUM_LINES-1:0]),
    .set_pd_i    (set_pd_all),
    .clr_pd_i    (clr_pd_pad[NUM_LINES-1:0]),
    .ack_mask_i  (ack_mask),
    .done_mask_i (done_mask),
    .en_o        (en),
    .pd_o        (pd),
    .act_o       (act)
  );

  ipc_arbiter #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pd_i   (pd),
    .en_i   (en),
    .act_i  (act),
    .prio_i (prio_q),
    .req_o  (irq_req_o),
    .id_o   (irq_id_o),
    .prio_o (irq_prio_o)
  );

  // Priority storage: upper nibble of each strobed byte lane.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      prio_q <= '0;
    end else if (wr_hit && dec.sel == SEL_PRIO) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (int'(dec.idx) == i / 4 && bus_be_i[i % 4])
          prio_q[i] <= bus_wdata_i[(i % 4) * 8 + 7 -: PRIO_W];
      end
    end
  end

  always_comb begin
    en_pad  = '0;
    pd_pad  = '0;
    act_pad = '0;
    en_pad[NUM_LINES-1:0]  = en;
    pd_pad[NUM_LINES-1:0]  = pd;
    act_pad[NUM_LINES-1:0] = act;
  end

  always_comb begin
    rd_word = '0;
    if (dec.sel == SEL_PRIO) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (int'(dec.idx) == i / 4) rd_word[(i % 4) * 8 + 7 -: PRIO_W] = prio_q[i];
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (int'(dec.idx) == w) begin
          case (dec.sel)
            SEL_EN_SET, SEL_EN_CLR: rd_word = en_pad[w*32 +: 32];
            SEL_PD_SET, SEL_PD_CLR: rd_word = pd_pad[w*32 +: 32];
            SEL_ACTIVE:             rd_word = act_pad[w*32 +: 32];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= rd_hit;
      if (rd_hit) bus_rdata_o <= rd_word;
    end
  end

  assert_read_latency_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> bus_rvalid_o);
  assert_no_spurious_rvalid_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> !bus_rvalid_o);
  assert_prio_low_bits_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && dec.sel == SEL_PRIO) |=> ((bus_rdata_o & unstored_mask()) == '0));
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/100ps
module test_irq_prio_ctrl;
  localparam int N  = 64;
  localparam int NW = (N + 31) / 32;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  lines = '0;
  logic          bvalid = 1'b0, bwrite = 1'b0;
  logic [7:0]    baddr = '0;
  logic [31:0]   bwdata = '0;
  logic [3:0]    bbe = '0;
  logic          rvalid;
  logic [31:0]   rdata;
  logic          req;
  logic [IW-1:0] id;
  logic [3:0]    prio;
  logic          ack = 1'b0, done = 1'b0;
  logic [IW-1:0] done_id = '0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
    .bus_valid_i(bvalid), .bus_write_i(bwrite), .bus_addr_i(baddr),
    .bus_wdata_i(bwdata), .bus_be_i(bbe), .bus_rvalid_o(rvalid), .bus_rdata_o(rdata),
    .irq_req_o(req), .irq_id_o(id), .irq_prio_o(prio),
    .irq_ack_i(ack), .irq_done_i(done), .irq_done_id_i(done_id)
  );

  // Behavioural reference state
  int    m_en[N], m_pd[N], m_act[N], m_prio[N], m_prev[N];
  bit    e_rvalid;
  int    e_rdata;
  int    n_checks = 0, n_fail = 0;
  string tag = "R13";

  function automatic int ref_read(int a);
    int v = 0;
    if (a >= 'h80 && a < 'hC0) begin
      for (int b = 0; b < 4; b++)
        if ((a - 'h80) * 4 + b < N) v |= m_prio[(a - 'h80) * 4 + b] << (b * 8 + 4);
    end else if (a < 'h28 && (a % 8) < NW) begin
      for (int b = 0; b < 32; b++) begin
        int ln = (a % 8) * 32 + b;
        int bitv = 0;
        if (ln < N) begin
          if (a / 8 <= 1) bitv = m_en[ln];
          else if (a / 8 <= 3) bitv = m_pd[ln];
          else bitv = m_act[ln];
        end
        if (bitv != 0) v |= 1 << b;
      end
    end
    return v;
  endfunction

  task automatic ref_winner(output bit r, output int wid, output int wp);
    int lowest_act = 16;
    wid = -1; wp = 16;
    foreach (m_act[i]) if (m_act[i] != 0 && m_prio[i] < lowest_act) lowest_act = m_prio[i];
    foreach (m_pd[i])
      if (m_pd[i] != 0 && m_en[i] != 0 && m_act[i] == 0 && m_prio[i] < wp) begin
        wid = i; wp = m_prio[i];
      end
    r = (wid >= 0) && (wp < lowest_act);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_en[i]) begin m_en[i] = 0; m_pd[i] = 0; m_act[i] = 0; m_prio[i] = 0; m_prev[i] = 0; end
      e_rvalid = 0; e_rdata = 0;
    end else begin
      bit wr; int wid, wp; int a; int d; int old_act[N];
      old_act = m_act;
      ref_winner(wr, wid, wp);
      e_rvalid = bvalid && !bwrite;
      if (e_rvalid) e_rdata = ref_read(int'(baddr));
      a = int'(baddr);
      d = int'(bwdata & {{8{bbe[3]}}, {8{bbe[2]}}, {8{bbe[1]}}, {8{bbe[0]}}});
      // clears first
      if (bvalid && bwrite && a >= 'h18 && a < 'h18 + NW)
        for (int b = 0; b < 32; b++)
          if (((d >> b) & 1) != 0 && (a - 'h18) * 32 + b < N && old_act[(a - 'h18) * 32 + b] == 0)
            m_pd[(a - 'h18) * 32 + b] = 0;
      if (ack && wr) m_pd[wid] = 0;
      if (done && int'(done_id) < N) m_act[int'(done_id)] = 0;
      if (ack && wr) m_act[wid] = 1;
      // sets and enable changes
      if (bvalid && bwrite) begin
        for (int b = 0; b < 32; b++) begin
          if (((d >> b) & 1) != 0) begin
            if (a < NW && a * 32 + b < N) m_en[a * 32 + b] = 1;
            if (a >= 'h08 && a < 'h08 + NW && (a - 'h08) * 32 + b < N) m_en[(a - 'h08) * 32 + b] = 0;
            if (a >= 'h10 && a < 'h10 + NW && (a - 'h10) * 32 + b < N) m_pd[(a - 'h10) * 32 + b] = 1;
          end
        end
        if (a >= 'h80 && a < 'hC0)
          for (int b = 0; b < 4; b++)
            if (bbe[b] && (a - 'h80) * 4 + b < N) m_prio[(a - 'h80) * 4 + b] = int'(bwdata[b*8+4 +: 4]);
        if (a == 'hC0 && int'(bwdata[8:0]) < 240 && int'(bwdata[8:0]) < N) m_pd[int'(bwdata[8:0])] = 1;
      end
      for (int i = 0; i < N; i++) begin
        if (lines[i] && m_prev[i] == 0) m_pd[i] = 1;
        m_prev[i] = lines[i] ? 1 : 0;
      end
    end
  end

  task automatic check(bit ok, string what, int act_v, int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit er; int eid, ep;
      ref_winner(er, eid, ep);
      check(req === er, "request", int'(req), int'(er));
      if (er) begin
        check(int'(id) == eid, "winner id", int'(id), eid);
        check(int'(prio) == ep, "winner priority", int'(prio), ep);
      end
      check(rvalid === e_rvalid, "read valid", int'(rvalid), int'(e_rvalid));
      if (e_rvalid) check(int'(rdata) == e_rdata, "read data", int'(rdata), e_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] dv, input logic [3:0] be);
    @(negedge clk); bvalid = 1; bwrite = 1; baddr = a; bwdata = dv; bbe = be;
    @(negedge clk); bvalid = 0; bwrite = 0;
  endtask
  task automatic rd(input logic [7:0] a);
    @(negedge clk); bvalid = 1; bwrite = 0; baddr = a;
    @(negedge clk); bvalid = 0;
  endtask
  task automatic pulse_ack();
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
  endtask
  task automatic pulse_done(input int ln);
    @(negedge clk); done = 1; done_id = IW'(ln); @(negedge clk); done = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R13"; rd(8'h00); rd(8'h01); rd(8'h10); rd(8'h20); rd(8'h80); rd(8'h30); rd(8'h02);
    tag = "R2"; wr(8'h00, 32'h0000_00F0, 4'b0001); wr(8'h01, 32'h8000_0001, 4'hF);
    wr(8'h00, 32'h0000_FF00, 4'b0001); rd(8'h00);
    tag = "R3"; rd(8'h08); rd(8'h09);
    tag = "R1"; rd(8'h01);
    tag = "R2"; wr(8'h08, 32'h0000_0020, 4'hF); rd(8'h00); wr(8'h00, 32'h0000_0020, 4'hF);
    tag = "R7"; wr(8'h81, 32'hF0A5_3C7F, 4'hF); rd(8'h81);
    wr(8'h81, 32'h0011_0000, 4'b0100); rd(8'h81); rd(8'h80);
    tag = "R4"; wr(8'h10, 32'h0000_00F1, 4'hF); rd(8'h10); rd(8'h18);
    wr(8'h10, 32'h0000_0040, 4'hF); rd(8'h10);
    tag = "R10"; idle(2); wr(8'h81, 32'h0000_1000, 4'b0010); idle(2);
    tag = "R12"; pulse_ack(); rd(8'h20); rd(8'h10);
    tag = "R11"; idle(2);
    tag = "R12"; pulse_ack(); rd(8'h20);
    tag = "R5"; wr(8'h10, 32'h0000_0020, 4'hF); wr(8'h18, 32'h0000_0020, 4'hF); rd(8'h10);
    tag = "R6"; wr(8'h20, 32'hFFFF_FFFF, 4'hF); rd(8'h20);
    tag = "R11"; wr(8'h11, 32'h0000_0001, 4'hF); idle(1); pulse_ack(); rd(8'h21);
    tag = "R12"; pulse_done(32); pulse_done(5); rd(8'h20); idle(2);
    tag = "R8"; wr(8'hC0, 32'd63, 4'h0); rd(8'h11); wr(8'hC0, 32'd64, 4'hF);
    wr(8'hC0, 32'd300, 4'hF); wr(8'hC0, 32'd239, 4'hF); rd(8'h11); rd(8'h10);
    tag = "R9"; wr(8'h01, 32'h0000_0100, 4'hF); wr(8'h18, 32'hFFFF_FFFF, 4'hF);
    @(negedge clk); lines[40] = 1; idle(2); rd(8'h11);
    wr(8'h19, 32'h0000_0100, 4'hF); idle(3); rd(8'h11);
    @(negedge clk); lines[40] = 0; idle(1); @(negedge clk); lines[40] = 1; idle(2); rd(8'h11);
    tag = "R10"; pulse_ack(); pulse_ack(); pulse_ack(); rd(8'h20); rd(8'h21);
    idle(3);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(100000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule